// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges four reset causes into a single active-high chip reset. The causes are a power-on indication, a digital flag from a supply-level comparator, an active-low external reset pin, and a reset request from a watchdog. The external pin is first brought into the clock domain by a two-stage synchronizer. It is then accepted only after it has stayed low for a minimum number of consecutive clocks, so short glitches on a board-level line cannot reset the chip.

While any accepted cause is present, the output reset is held high. It rises in the same cycle as a power-on, supply-low or watchdog input. After the last cause goes away, the output stays high for a fixed stretch of `STRETCH_CYC` clock cycles. The default is 600,000 cycles, about 150 ms at 4 MHz. The output then falls on a clock edge. If any cause appears during the stretch, the count starts over from the moment that cause goes away.

The power-on input also serves as the block's own synchronous reset.

Top module: `rstseq_top`

## Requirements
- R1: While `por_i` is high, `rst_o` is high. After `por_i` falls with no other cause present, `rst_o` stays high for exactly `STRETCH_CYC` rising edges and is low after the last of them.
- R2: While `lowv_i` is high, `rst_o` is high in every cycle, starting in the same cycle that `lowv_i` rises.
- R3: After `lowv_i` falls with no other cause present, `rst_o` stays high for exactly `STRETCH_CYC` rising edges.
- R4: An external reset is accepted when `ext_rst_n_i` is sampled low at `MIN_LOW` consecutive rising edges. `rst_o` then rises after rising edge number `MIN_LOW`+2, counted from the first low sample. The extra two edges come from the synchronizer.
- R5: A low period on `ext_rst_n_i` shorter than `MIN_LOW` samples has no effect: `rst_o` stays low. A single high sample restarts the low-width count, so short low periods never add up.
- R6: After an accepted external reset, once the pin is sampled high again, `rst_o` stays high for exactly `STRETCH_CYC`+3 rising edges. The extra three edges are two synchronizer stages plus one cycle for the qualifier to clear.
- R7: `wdog_i` drives `rst_o` high in the same cycle. A single-cycle request is followed by exactly `STRETCH_CYC` rising edges of reset after it drops.
- R8: A cause that appears while the stretch is running restarts the stretch. `rst_o` never drops in between, and it stays high for the full stretch length measured from that cause's release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on indication, active high; also the block's synchronous reset |
| lowv_i | input | 1 | Supply-below-threshold flag, active high |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous to `clk` |
| wdog_i | input | 1 | Watchdog reset request, active high, synchronous |
| rst_o | output | 1 | Combined chip reset, active high |

## Verification
The bench sweeps the external low width from one cycle up to several cycles past `MIN_LOW`. A qualifier that is off by one would accept a width one short of the limit or miss the exact limit. A missing synchronizer stage or an extra one would shift both the onset and the release count that the bench computes. Two short low periods split by one high sample target a qualifier that fails to restart, which would wrongly reset the chip. Stretch lengths are counted edge by edge after each kind of release, and a watchdog pulse plus an external reset arrive in the middle of a running stretch. A counter that kept running or measured from assertion would release too early.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    // One bit per reset cause; the order carries no meaning.
    typedef struct packed {
        logic por;
        logic lowv;
        logic ext;
        logic wdog;
    } rst_src_t;

    typedef enum logic [1:0] {
        PH_RUN     = 2'd0,
        PH_HOLD    = 2'd1,
        PH_STRETCH = 2'd2
    } rst_phase_e;

    function automatic logic any_src(input rst_src_t s);
        return s.por | s.lowv | s.ext | s.wdog;
    endfunction

    // Bits needed to hold values 0..n.
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic clr,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (clr) chain <= RST_VAL;
                else     chain <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (clr) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rstseq_qual.sv
module rstseq_qual
    import rstseq_pkg::*;
#(
    parameter int unsigned MIN_LOW = 10
) (
    input  logic clk,
    input  logic clr,
    input  logic lvl_n_i,
    output logic hit_o
);
    localparam int unsigned QW = cnt_w(MIN_LOW);
    localparam logic [QW-1:0] LIMIT = QW'(MIN_LOW);

    logic [QW-1:0] run;

    // Counts consecutive low samples, saturating at the limit; any high sample clears it.
    always_ff @(posedge clk) begin
        if (clr || lvl_n_i) run <= '0;
        else if (run != LIMIT) run <= run + 1'b1;
    end

    assign hit_o = (run == LIMIT);
endmodule

// File: rtl/rstseq_stretch.sv
module rstseq_stretch
    import rstseq_pkg::*;
#(
    parameter int unsigned LEN = 600000
) (
    input  logic clk,
    input  logic hold_i,
    output logic rst_o
);
    localparam int unsigned CW = cnt_w(LEN);
    localparam logic [CW-1:0] LOAD = CW'(LEN);

    logic [CW-1:0] remain;
    rst_phase_e    phase;

    // Reloaded every cycle a cause is present, so the count always starts at release.
    always_ff @(posedge clk) begin
        if (hold_i)            remain <= LOAD;
        else if (remain != '0) remain <= remain - 1'b1;
    end

    always_comb begin
        if (hold_i)            phase = PH_HOLD;
        else if (remain != '0) phase = PH_STRETCH;
        else                   phase = PH_RUN;
    end

    assign rst_o = (phase != PH_RUN);
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int unsigned STRETCH_CYC = 600000,
    parameter int unsigned MIN_LOW     = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_i,
    input  logic lowv_i,
    input  logic ext_rst_n_i,
    input  logic wdog_i,
    output logic rst_o
);
    logic     pin_sync;
    logic     ext_hit;
    logic     hold_any;
    rst_src_t src;

    rstseq_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk(clk),
        .clr(por_i),
        .d_i(ext_rst_n_i),
        .q_o(pin_sync)
    );

    rstseq_qual #(
        .MIN_LOW(MIN_LOW)
    ) u_qual (
        .clk    (clk),
        .clr    (por_i),
        .lvl_n_i(pin_sync),
        .hit_o  (ext_hit)
    );

    always_comb begin
        src.por  = por_i;
        src.lowv = lowv_i;
        src.ext  = ext_hit;
        src.wdog = wdog_i;
    end

    assign hold_any = any_src(src);

    rstseq_stretch #(
        .LEN(STRETCH_CYC)
    ) u_stretch (
        .clk   (clk),
        .hold_i(hold_any),
        .rst_o (rst_o)
    );
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk
    import rstseq_pkg::*;
#(
    parameter int unsigned STRETCH_CYC = 600000,
    parameter int unsigned MIN_LOW     = 10
) (
    input logic clk,
    input logic por_i,
    input logic lowv_i,
    input logic ext_rst_n_i,
    input logic wdog_i,
    input logic ext_hit,
    input logic hold_any,
    input logic rst_o
);
    localparam int unsigned RW = cnt_w(STRETCH_CYC + 1);
    localparam int unsigned LW = cnt_w(MIN_LOW + 3);
    localparam logic [RW-1:0] REL_MAX = RW'(STRETCH_CYC + 1);
    localparam logic [LW-1:0] LOW_MAX = LW'(MIN_LOW + 3);

    logic [RW-1:0] rel_cnt;
    logic [LW-1:0] low_run;

    // Cycles of reset seen since the last cause went away.
    always_ff @(posedge clk) begin
        if (por_i || hold_any)               rel_cnt <= '0;
        else if (rst_o && rel_cnt != REL_MAX) rel_cnt <= rel_cnt + 1'b1;
    end

    // Consecutive low samples of the raw pin.
    always_ff @(posedge clk) begin
        if (por_i || ext_rst_n_i)  low_run <= '0;
        else if (low_run != LOW_MAX) low_run <= low_run + 1'b1;
    end

    // R2
    a_r2_lowv_holds: assert property (@(posedge clk) disable iff (por_i)
        lowv_i |-> rst_o);

    // R7
    a_r7_wdog_immediate: assert property (@(posedge clk) disable iff (por_i)
        wdog_i |-> rst_o);

    // R3
    a_r3_stretch_length: assert property (@(posedge clk) disable iff (por_i)
        $fell(rst_o) |-> (rel_cnt == RW'(STRETCH_CYC)));

    // R8
    a_r8_hold_keeps_reset: assert property (@(posedge clk) disable iff (por_i)
        hold_any |=> rst_o);

    // R4
    a_r4_ext_min_width: assert property (@(posedge clk) disable iff (por_i)
        $rose(ext_hit) |-> ($past(low_run, 2) >= LW'(MIN_LOW)));
endmodule

bind rstseq_top rstseq_chk #(
    .STRETCH_CYC(STRETCH_CYC),
    .MIN_LOW    (MIN_LOW)
) u_chk (
    .clk        (clk),
    .por_i      (por_i),
    .lowv_i     (lowv_i),
    .ext_rst_n_i(ext_rst_n_i),
    .wdog_i     (wdog_i),
    .ext_hit    (ext_hit),
    .hold_any   (hold_any),
    .rst_o      (rst_o)
);

// File: tb/sim_rstseq_top.sv
module sim_rstseq_top;
    localparam int S = 40;
    localparam int M = 10;

    logic clk = 1'b0;
    logic por_i = 1'b1;
    logic lowv_i = 1'b0;
    logic ext_n = 1'b1;
    logic wdog_i = 1'b0;
    logic rst_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rstseq_top #(
        .STRETCH_CYC(S),
        .MIN_LOW    (M),
        .SYNC_STAGES(2)
    ) u0 (
        .clk        (clk),
        .por_i      (por_i),
        .lowv_i     (lowv_i),
        .ext_rst_n_i(ext_n),
        .wdog_i     (wdog_i),
        .rst_o      (rst_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts negedges after a release until rst_o reads low.
    task automatic count_release(input int exp, input string req);
        int k;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (rst_o && k < exp + 60);
        check(k == exp, req, k, exp);
    endtask

    initial begin
        int first;
        int k;
        int bad;

        // R1: reset state and power-on stretch
        repeat (4) begin
            @(negedge clk);
            check(rst_o == 1'b1, "R1 por hold", int'(rst_o), 1);
        end
        por_i = 1'b0;
        count_release(S, "R1 por stretch");
        @(negedge clk);
        check(rst_o == 1'b0, "R1 idle", int'(rst_o), 0);

        // R2 / R3: supply-low hold then stretch
        lowv_i = 1'b1;
        #1 check(rst_o == 1'b1, "R2 same cycle", int'(rst_o), 1);
        bad = 0;
        repeat (80) begin
            @(negedge clk);
            if (!rst_o) bad++;
        end
        check(bad == 0, "R2 continuous", bad, 0);
        lowv_i = 1'b0;
        count_release(S, "R3 lowv stretch");

        // R7: watchdog pulse
        @(negedge clk);
        wdog_i = 1'b1;
        #1 check(rst_o == 1'b1, "R7 immediate", int'(rst_o), 1);
        @(negedge clk);
        wdog_i = 1'b0;
        count_release(S, "R7 wdog stretch");

        // R8: watchdog during a running stretch
        @(negedge clk);
        lowv_i = 1'b1;
        repeat (3) @(negedge clk);
        lowv_i = 1'b0;
        repeat (S / 2) @(negedge clk);
        check(rst_o == 1'b1, "R8 mid stretch", int'(rst_o), 1);
        wdog_i = 1'b1;
        @(negedge clk);
        wdog_i = 1'b0;
        count_release(S, "R8 restart by wdog");

        // R8: qualified external reset during a running stretch
        @(negedge clk);
        lowv_i = 1'b1;
        @(negedge clk);
        lowv_i = 1'b0;
        repeat (5) @(negedge clk);
        ext_n = 1'b0;
        repeat (M + 4) @(negedge clk);
        ext_n = 1'b1;
        count_release(S + 3, "R8 restart by ext");
        repeat (3) @(negedge clk);

        // R4 / R5 / R6: sweep of external low width
        for (int L = 1; L <= M + 6; L++) begin
            first = 0;
            ext_n = 1'b0;
            for (int i = 1; i <= L; i++) begin
                @(negedge clk);
                if (rst_o && first == 0) first = i;
            end
            ext_n = 1'b1;
            k = 0;
            do begin
                @(negedge clk);
                k++;
                if (rst_o && first == 0) first = L + k;
            end while ((rst_o || k < 4) && k < S + 60);
            if (L >= M) begin
                check(first == M + 2, "R4 onset", first, M + 2);
                check(k == S + 3, "R6 ext stretch", k, S + 3);
            end else begin
                check(first == 0, "R5 short low ignored", first, 0);
            end
            repeat (3) @(negedge clk);
        end

        // R5: two short lows split by one high sample do not add up
        first = 0;
        ext_n = 1'b0;
        repeat (M - 2) begin
            @(negedge clk);
            if (rst_o) first = 1;
        end
        ext_n = 1'b1;
        @(negedge clk);
        if (rst_o) first = 1;
        ext_n = 1'b0;
        repeat (M - 2) begin
            @(negedge clk);
            if (rst_o) first = 1;
        end
        ext_n = 1'b1;
        repeat (M + 4) begin
            @(negedge clk);
            if (rst_o) first = 1;
        end
        check(first == 0, "R5 split lows", first, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule